// File: doc/BRIEF.md
# Hardware Lock Bank

This block holds a bank of single-bit lock flags that several bus masters share so that they can serialize access to a common resource. Every lock has its own word-aligned register. A master claims a lock by reading that register. A result of 0 means the lock was free and now belongs to the reader. A result of 1 means another master holds it. The holder frees the lock by writing 0 to the same register. A read-only status word tells software how many locks the bank was built with.

The bank has `NPORTS` independent register ports, and each port has an address, a read strobe, a write strobe, write data and read data. Each port carries one complete access per cycle. A port has no valid/ready handshake and never applies back-pressure: every strobe is accepted in the cycle it is presented. When several ports reach the same lock in one cycle, the port with the lowest index is served first, so only one reader can win.

Top module: `hwlock_bank`

## Requirements
- R1: A read of offset 0x000 returns the status word, which holds `log2(LOCK_COUNT) - 4` in bits 31:28 and 0 in every other bit. For the default of 32 locks this is 0x10000000.
- R2: Lock i sits at offset 0x100 + 4*i. A read of a free lock returns 0 and marks the lock taken.
- R3: A read of a taken lock returns 1 and leaves the lock taken.
- R4: A write of 0 to a lock register frees that lock, and the next read of it returns 0.
- R5: A write of a nonzero value to a lock register has no effect. A write to the status word has no effect.
- R6: Reset frees every lock.
- R7: When two or more ports read the same free lock in one cycle, the lowest-indexed of those ports gets 0 and every other port gets 1.
- R8: A read of an unmapped offset, of a misaligned offset, or of a lock index at or above `LOCK_COUNT` returns 0 and changes no lock. A write to any such offset changes no lock.
- R9: Read data appears in the cycle after the read strobe. In a cycle that follows no read, the read data is 0.
- R10: A read that shares a cycle with another port's release of the same taken lock returns 1, and the lock is free in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | NPORTS*ADDR_W | Byte address for each port; port p uses slice p |
| bus_rd | input | NPORTS | Read strobe for each port |
| bus_wr | input | NPORTS | Write strobe for each port |
| bus_wdata | input | NPORTS*32 | Write data for each port |
| bus_rdata | output | NPORTS*32 | Registered read data for each port |

## Verification
A read result is due exactly one clock edge after the cycle that holds its strobe. A claim or release takes effect at that same edge, so a read in the next cycle already sees it. The bench drives each access on a falling edge and samples the read data on the following falling edge, which places the check in the middle of the cycle where the result is due. For tests where the sampled data alone does not show the effect of an access, such as ignored writes, races and reset, the bench issues a follow-up read of the affected lock and compares its result in the same way.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int unsigned WORD_W = 32;

  // One port's decoded access for the current cycle
  typedef struct packed {
    logic stat_rd;   // read of the status word
    logic lock_rd;   // read of a mapped lock (test and claim)
    logic lock_rel;  // write of zero to a mapped lock
  } acc_t;

  // Encoded lock count: 32 -> 1, 64 -> 2, 128 -> 3, 256 -> 4
  function automatic logic [3:0] count_code(input int unsigned n);
    return 4'($clog2(n) - 4);
  endfunction
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned LOCK_COUNT = 32,
  localparam int unsigned IDX_W     = $clog2(LOCK_COUNT)
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       rd,
  input  logic                       wr,
  input  logic [hwlock_pkg::WORD_W-1:0] wdata,
  output hwlock_pkg::acc_t           acc,
  output logic [IDX_W-1:0]           idx
);
  localparam logic [ADDR_W-1:0] LOCK_BASE = ADDR_W'('h100);

  logic [ADDR_W-1:0] off;
  logic              in_lock;
  logic              is_stat;

  always_comb begin
    off     = addr - LOCK_BASE;
    in_lock = (addr >= LOCK_BASE) && (off[1:0] == 2'b00)
              && ((off >> 2) < ADDR_W'(LOCK_COUNT));
    is_stat = (addr == '0);
    idx     = off[IDX_W+1:2];
    acc.stat_rd  = rd & is_stat;
    acc.lock_rd  = rd & in_lock;
    acc.lock_rel = wr & in_lock & (wdata == '0);
  end
endmodule

// File: rtl/hwlock_flags.sv
module hwlock_flags #(
  parameter int unsigned LOCK_COUNT = 32,
  parameter int unsigned NPORTS     = 2,
  localparam int unsigned IDX_W     = $clog2(LOCK_COUNT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS-1:0]       rd_en,
  input  logic [NPORTS-1:0]       rel_en,
  input  logic [NPORTS*IDX_W-1:0] idx_flat,
  output logic [NPORTS-1:0]       seen
);
  logic [LOCK_COUNT-1:0] flags_q;
  logic [LOCK_COUNT-1:0] claim_acc;
  logic [LOCK_COUNT-1:0] rel_acc;
  logic [IDX_W-1:0]      idx [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_idx
    assign idx[p] = idx_flat[p*IDX_W +: IDX_W];
  end

  // Lower port index is served first: a later port sees earlier claims
  always_comb begin
    claim_acc = '0;
    rel_acc   = '0;
    seen      = '0;
    for (int p = 0; p < NPORTS; p++) begin
      seen[p] = flags_q[idx[p]] | claim_acc[idx[p]];
      if (rd_en[p] && !seen[p]) claim_acc[idx[p]] = 1'b1;
      if (rel_en[p])            rel_acc[idx[p]]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~rel_acc) | claim_acc;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[p] && !seen[p]) |=> flags_q[$past(idx[p])]); // R2
    AST_TAKEN_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[p] && flags_q[idx[p]]) |-> seen[p]); // R3
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en[p] && flags_q[idx[p]]) |=> !flags_q[$past(idx[p])]); // R4
    for (genvar q = p + 1; q < NPORTS; q++) begin : g_pair
      AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[p] && rd_en[q] && idx[p] == idx[q]) |-> (seen[p] || seen[q])); // R7
    end
  end
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank #(
  parameter int unsigned LOCK_COUNT = 32,
  parameter int unsigned NPORTS     = 2,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*ADDR_W-1:0] bus_addr,
  input  logic [NPORTS-1:0]        bus_rd,
  input  logic [NPORTS-1:0]        bus_wr,
  input  logic [NPORTS*32-1:0]     bus_wdata,
  output logic [NPORTS*32-1:0]     bus_rdata
);
  import hwlock_pkg::*;

  localparam int unsigned IDX_W = $clog2(LOCK_COUNT);
  localparam logic [WORD_W-1:0] STATUS_WORD = {count_code(LOCK_COUNT), 28'h0};

  acc_t                    acc [NPORTS];
  logic [NPORTS*IDX_W-1:0] idx_flat;
  logic [NPORTS-1:0]       rd_en;
  logic [NPORTS-1:0]       rel_en;
  logic [NPORTS-1:0]       seen;
  logic [WORD_W-1:0]       rdata_q [NPORTS];

  initial begin
    AST_COUNT_LEGAL: assert (LOCK_COUNT == 32 || LOCK_COUNT == 64 ||
                             LOCK_COUNT == 128 || LOCK_COUNT == 256); // R1
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    hwlock_decode #(.ADDR_W(ADDR_W), .LOCK_COUNT(LOCK_COUNT)) u_dec (
      .addr  (bus_addr[p*ADDR_W +: ADDR_W]),
      .rd    (bus_rd[p]),
      .wr    (bus_wr[p]),
      .wdata (bus_wdata[p*WORD_W +: WORD_W]),
      .acc   (acc[p]),
      .idx   (idx_flat[p*IDX_W +: IDX_W])
    );
    assign rd_en[p]  = acc[p].lock_rd;
    assign rel_en[p] = acc[p].lock_rel;

    always_ff @(posedge clk) begin
      if (!rst_n)              rdata_q[p] <= '0;
      else if (acc[p].stat_rd) rdata_q[p] <= STATUS_WORD;
      else if (acc[p].lock_rd) rdata_q[p] <= {{(WORD_W-1){1'b0}}, seen[p]};
      else                     rdata_q[p] <= '0;
    end
    assign bus_rdata[p*WORD_W +: WORD_W] = rdata_q[p];

    AST_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd[p] && bus_addr[p*ADDR_W +: ADDR_W] == '0)
      |=> bus_rdata[p*WORD_W +: WORD_W] == STATUS_WORD); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd[p] |=> bus_rdata[p*WORD_W +: WORD_W] == '0); // R9
    AST_LOCK_DATA_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      acc[p].lock_rd |=> bus_rdata[p*WORD_W+1 +: WORD_W-1] == '0); // R2
  end

  hwlock_flags #(.LOCK_COUNT(LOCK_COUNT), .NPORTS(NPORTS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rel_en   (rel_en),
    .idx_flat (idx_flat),
    .seen     (seen)
  );
endmodule

// File: tb/test_hwlock_bank.sv
module test_hwlock_bank;
  localparam int NP = 2;
  localparam int AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP*AW-1:0]  bus_addr = '0;
  logic [NP-1:0]     bus_rd = '0;
  logic [NP-1:0]     bus_wr = '0;
  logic [NP*32-1:0]  bus_wdata = '0;
  logic [NP*32-1:0]  bus_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hwlock_bank #(.LOCK_COUNT(32), .NPORTS(NP), .ADDR_W(AW)) i_hwlock_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // One cycle with both ports driven; returns the data sampled a cycle later
  task automatic cyc(input logic [AW-1:0] a0, input logic r0, input logic w0, input logic [31:0] d0,
                     input logic [AW-1:0] a1, input logic r1, input logic w1, input logic [31:0] d1,
                     output logic [31:0] q0, output logic [31:0] q1);
    @(negedge clk);
    bus_addr  = {a1, a0};
    bus_rd    = {r1, r0};
    bus_wr    = {w1, w0};
    bus_wdata = {d1, d0};
    @(negedge clk);
    q0 = bus_rdata[31:0];
    q1 = bus_rdata[63:32];
    bus_rd = '0;
    bus_wr = '0;
  endtask

  task automatic rd0(input logic [AW-1:0] a, output logic [31:0] q);
    logic [31:0] unused_q;
    cyc(a, 1'b1, 1'b0, 32'h0, '0, 1'b0, 1'b0, 32'h0, q, unused_q);
  endtask

  task automatic wr0(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] x0, x1;
    cyc(a, 1'b0, 1'b1, d, '0, 1'b0, 1'b0, 32'h0, x0, x1);
  endtask

  task automatic t_reset_state();
    logic [31:0] q;
    rd0(12'h000, q); chk("R1 status word", q, 32'h1000_0000);
    rd0(12'h114, q); chk("R6 lock5 free after reset", q, 32'h0);
  endtask

  task automatic t_claim();
    logic [31:0] q;
    rd0(12'h114, q); chk("R3 lock5 taken", q, 32'h1);
    rd0(12'h17C, q); chk("R2 lock31 claim", q, 32'h0);
    rd0(12'h17C, q); chk("R3 lock31 held", q, 32'h1);
  endtask

  task automatic t_release();
    logic [31:0] q;
    wr0(12'h114, 32'h0);
    rd0(12'h114, q); chk("R4 lock5 freed", q, 32'h0);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] q;
    wr0(12'h114, 32'hFFFF_FFFF);
    rd0(12'h114, q); chk("R5 nonzero write ignored", q, 32'h1);
    wr0(12'h000, 32'h0);
    rd0(12'h000, q); chk("R5 status write ignored", q, 32'h1000_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] q;
    rd0(12'h180, q); chk("R8 index 32 reads zero", q, 32'h0);
    rd0(12'h180, q); chk("R8 index 32 no claim", q, 32'h0);
    rd0(12'h106, q); chk("R8 misaligned reads zero", q, 32'h0);
    rd0(12'h080, q); chk("R8 unmapped reads zero", q, 32'h0);
    rd0(12'h104, q); chk("R8 lock1 untouched by misaligned read", q, 32'h0);
    wr0(12'h106, 32'h0);
    rd0(12'h104, q); chk("R8 misaligned write ignored", q, 32'h1);
  endtask

  task automatic t_race();
    logic [31:0] q0, q1;
    cyc(12'h11C, 1'b1, 1'b0, 32'h0, 12'h11C, 1'b1, 1'b0, 32'h0, q0, q1);
    chk("R7 port0 wins", q0, 32'h0);
    chk("R7 port1 loses", q1, 32'h1);
    cyc(12'h11C, 1'b0, 1'b1, 32'h0, 12'h11C, 1'b1, 1'b0, 32'h0, q0, q1);
    chk("R10 read during release", q1, 32'h1);
    cyc(12'h000, 1'b0, 1'b0, 32'h0, 12'h11C, 1'b1, 1'b0, 32'h0, q0, q1);
    chk("R10 free after release", q1, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] q;
    rd0(12'h120, q); chk("R9 data one cycle after strobe", q, 32'h0);
    rd0(12'h120, q); chk("R9 second read", q, 32'h1);
    @(negedge clk);
    chk("R9 idle cycle data zero", bus_rdata[31:0], 32'h0);
  endtask

  task automatic t_reset_clears();
    logic [31:0] q;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    rd0(12'h114, q); chk("R6 lock5 cleared", q, 32'h0);
    rd0(12'h17C, q); chk("R6 lock31 cleared", q, 32'h0);
    rd0(12'h120, q); chk("R6 lock8 cleared", q, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_claim();
    t_release();
    t_ignored_writes();
    t_unmapped();
    t_race();
    t_timing();
    t_reset_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule